// File: doc/BRIEF.md
# Parity-Framed Multi-Lane Pixel Serializer

This block takes one parallel pixel word per pixel-clock period. The word holds 24 colour bits plus horizontal sync, vertical sync and data-enable. The block wraps the word in a 30-bit frame that adds an odd-parity bit and two reserved zero bits. It then shifts the frame out over one, two or three serial lanes. The number of lanes comes from a two-bit link select, so each lane carries 30, 15 or 10 bits per pixel. A bit-step enable, supplied from outside at the matching multiple of the pixel rate, drives the shifting.

The block and its step enable run on one fast clock. The pixel clock arrives as a level and is sampled on that clock. A polarity input chooses whether the rising or the falling pixel edge captures the bus, and a swap input reverses the whole colour bus for boards where the source sits on the other side. A registered copy of the pixel clock is sent alongside the lanes with a fixed polarity. Per-lane enable outputs mark which lanes carry data and stand in for a driver's high-impedance state.

Top module: `pix_lane_serializer`

## Requirements
- R1: Frame bit 0 is parity. Bits 1..8 are R7..R0, bits 9..16 are G7..G0 and bits 17..24 are B7..B0. Bit 25 is hSync, bit 26 is vSync and bit 27 is dataEn. Bits 28 and 29 are reserved and always 0.
- R2: The parity bit makes the count of ones across frame bits 0..27 odd. The reserved bits are not counted.
- R3: linkSel = {ls1, ls0} selects the lanes: 2'b00 gives one lane, 2'b01 gives two lanes, 2'b10 gives three lanes, and the reserved 2'b11 behaves as one lane. The setting is taken at each capture edge.
- R4: With N active lanes, lane i at step j carries frame bit j*N+i, for j from 0 to 30/N-1. Step 0 is presented right after the frame loads. Each later step needs one bitEn cycle, and once the last step is reached the lanes hold their value.
- R5: laneOe is 0 from reset until the first capture edge. After that, laneOe bits 0..N-1 are 1 and the others are 0. A lane whose enable is 0 outputs 0 on laneData.
- R6: When clkPol is 0 the rising pixClk edge captures the inputs; when clkPol is 1 the falling edge does. Input changes presented with the opposite edge are ignored.
- R7: When busSwap is 0, pixData[23:16] is R7..R0, pixData[15:8] is G7..G0 and pixData[7:0] is B7..B0. When busSwap is 1, the whole 24-bit bus is bit-reversed first, so pixData[0] is R7 and pixData[23] is B0.
- R8: The word captured at one capture edge starts on the lanes at the next capture edge. The held word resets to all zeros, so the first frame after reset is the zero word with parity 1.
- R9: If a capture edge and bitEn fall in the same clock cycle, the load wins and step 0 of the new frame is presented.
- R10: fwdClk equals pixClk delayed by one clock cycle, whatever the value of clkPol.
- R11: While reset is held, laneData, laneOe and fwdClk are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; pixel clock and step enable are sampled on it |
| rstN | input | 1 | Active-low synchronous reset |
| pixClk | input | 1 | Pixel clock level |
| bitEn | input | 1 | Step enable that advances the lanes by one bit |
| clkPol | input | 1 | Capture edge: 0 rising, 1 falling |
| busSwap | input | 1 | 1 reverses the colour bus bit order |
| linkSel | input | 2 | Lane count select {ls1, ls0} |
| pixData | input | 24 | Colour bus |
| hSync | input | 1 | Horizontal sync |
| vSync | input | 1 | Vertical sync |
| dataEn | input | 1 | Data enable |
| laneData | output | 3 | Serial bit per lane |
| laneOe | output | 3 | Per-lane output enable |
| fwdClk | output | 1 | Forwarded pixel clock |

## Verification
A pixel capture and a bit step can land in the same clock cycle. The capture must restart the frame, and the step must not shift the freshly loaded frame by one position. The sweep runs every combination of polarity, link select and bus order twice. In one run bitEn is low on the capture cycle, and in the other it is driven high on that exact cycle. In both runs the first lane sample after capture must be step 0 of the expected frame. The bench also presents junk data, a flipped bus order and a different link select together with the non-capture edge, and the next frame must be unaffected by them.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

  typedef struct packed {
    logic       capture;
    logic       shift;
    logic [1:0] laneNum;
  } pxsStrobe_t;

  function automatic logic [1:0] decodeLanes(input logic [1:0] sel);
    case (sel)
      2'b01:   return 2'd2;
      2'b10:   return 2'd3;
      default: return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/pxs_ctrl.sv
module pxs_ctrl
  import pxs_pkg::*;
#(
  parameter int FRAME_BITS = 30,
  parameter int MAX_LANES  = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pixClk,
  input  logic                 bitEn,
  input  logic                 clkPol,
  input  logic [1:0]           linkSel,
  output pxsStrobe_t           strobe,
  output logic [MAX_LANES-1:0] laneOe,
  output logic                 fwdClk
);
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST1 = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] LAST2 = CNT_W'(FRAME_BITS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST3 = CNT_W'(FRAME_BITS / 3 - 1);

  logic             pixClkQ;
  logic             running;
  logic [1:0]       laneNumQ;
  logic [CNT_W-1:0] stepCnt;
  logic [CNT_W-1:0] lastStep;
  logic             capEv;
  logic             shiftOk;

  // capture on the transition towards the selected level
  assign capEv = clkPol ? (pixClkQ & ~pixClk) : (~pixClkQ & pixClk);

  always_comb begin
    case (laneNumQ)
      2'd2:    lastStep = LAST2;
      2'd3:    lastStep = LAST3;
      default: lastStep = LAST1;
    endcase
  end

  // a load always beats a step in the same cycle
  assign shiftOk = bitEn & ~capEv & (stepCnt < lastStep);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixClkQ  <= 1'b0;
      running  <= 1'b0;
      laneNumQ <= 2'd1;
      stepCnt  <= '0;
    end else begin
      pixClkQ <= pixClk;
      if (capEv) begin
        running  <= 1'b1;
        laneNumQ <= decodeLanes(linkSel);
        stepCnt  <= '0;
      end else if (shiftOk) begin
        stepCnt <= stepCnt + 1'b1;
      end
    end
  end

  assign strobe.capture = capEv;
  assign strobe.shift   = shiftOk;
  assign strobe.laneNum = laneNumQ;
  assign fwdClk         = pixClkQ;

  for (genvar i = 0; i < MAX_LANES; i++) begin : g_oe
    assign laneOe[i] = running && (laneNumQ > 2'(i));
  end

  AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    stepCnt <= lastStep); // R4
  AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    capEv |=> (stepCnt == '0)); // R9
  AST_OE_CONTIG_HI: assert property (@(posedge clk) disable iff (!rstN)
    laneOe[2] |-> laneOe[1]); // R5
  AST_OE_CONTIG_LO: assert property (@(posedge clk) disable iff (!rstN)
    laneOe[1] |-> laneOe[0]); // R5

endmodule

// File: rtl/pxs_datapath.sv
module pxs_datapath
  import pxs_pkg::*;
#(
  parameter int PIX_BITS   = 24,
  parameter int RSV_BITS   = 2,
  parameter int MAX_LANES  = 3,
  parameter int FRAME_BITS = PIX_BITS + 4 + RSV_BITS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pxsStrobe_t           strobe,
  input  logic [PIX_BITS-1:0]  pixData,
  input  logic                 hSync,
  input  logic                 vSync,
  input  logic                 dataEn,
  input  logic                 busSwap,
  input  logic [MAX_LANES-1:0] laneOe,
  output logic [MAX_LANES-1:0] laneData
);
  localparam int WORD_BITS = PIX_BITS + 3;

  logic [PIX_BITS-1:0]   busRev;
  logic [PIX_BITS-1:0]   busOrd;
  logic [WORD_BITS-1:0]  holdWord;
  logic [FRAME_BITS-1:0] shiftReg;

  for (genvar b = 0; b < PIX_BITS; b++) begin : g_rev
    assign busRev[b] = pixData[PIX_BITS-1-b];
  end
  assign busOrd = busSwap ? busRev : pixData;

  function automatic logic [FRAME_BITS-1:0] packFrame(input logic [WORD_BITS-1:0] w);
    logic [FRAME_BITS-1:0] f;
    f    = '0;
    f[0] = ~^w;
    for (int b = 0; b < PIX_BITS; b++) f[1+b] = w[PIX_BITS-1-b];
    f[PIX_BITS+1] = w[PIX_BITS];
    f[PIX_BITS+2] = w[PIX_BITS+1];
    f[PIX_BITS+3] = w[PIX_BITS+2];
    return f;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdWord <= '0;
      shiftReg <= '0;
    end else if (strobe.capture) begin
      shiftReg <= packFrame(holdWord);
      holdWord <= {dataEn, vSync, hSync, busOrd};
    end else if (strobe.shift) begin
      shiftReg <= shiftReg >> strobe.laneNum;
    end
  end

  assign laneData = laneOe & shiftReg[MAX_LANES-1:0];

  AST_SHIFT_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.capture || strobe.shift) |=> $stable(shiftReg)); // R4
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    shiftReg[FRAME_BITS-1 -: RSV_BITS] == '0); // R1

endmodule

// File: rtl/pix_lane_serializer.sv
module pix_lane_serializer
  import pxs_pkg::*;
#(
  parameter int PIX_BITS  = 24,
  parameter int RSV_BITS  = 2,
  parameter int MAX_LANES = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pixClk,
  input  logic                 bitEn,
  input  logic                 clkPol,
  input  logic                 busSwap,
  input  logic [1:0]           linkSel,
  input  logic [PIX_BITS-1:0]  pixData,
  input  logic                 hSync,
  input  logic                 vSync,
  input  logic                 dataEn,
  output logic [MAX_LANES-1:0] laneData,
  output logic [MAX_LANES-1:0] laneOe,
  output logic                 fwdClk
);
  localparam int FRAME_BITS = PIX_BITS + 4 + RSV_BITS;

  pxsStrobe_t strobe;

  pxs_ctrl #(
    .FRAME_BITS(FRAME_BITS),
    .MAX_LANES (MAX_LANES)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .pixClk (pixClk),
    .bitEn  (bitEn),
    .clkPol (clkPol),
    .linkSel(linkSel),
    .strobe (strobe),
    .laneOe (laneOe),
    .fwdClk (fwdClk)
  );

  pxs_datapath #(
    .PIX_BITS  (PIX_BITS),
    .RSV_BITS  (RSV_BITS),
    .MAX_LANES (MAX_LANES),
    .FRAME_BITS(FRAME_BITS)
  ) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .pixData (pixData),
    .hSync   (hSync),
    .vSync   (vSync),
    .dataEn  (dataEn),
    .busSwap (busSwap),
    .laneOe  (laneOe),
    .laneData(laneData)
  );

  for (genvar i = 0; i < MAX_LANES; i++) begin : g_quiet
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      !laneOe[i] |-> !laneData[i]); // R5
  end

endmodule

// File: tb/pix_lane_serializer_bench.sv
module pix_lane_serializer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pixClk = 1'b0;
  logic        bitEn = 1'b0;
  logic        clkPol = 1'b0;
  logic        busSwap = 1'b0;
  logic [1:0]  linkSel = 2'b00;
  logic [23:0] pixData = '0;
  logic        hSync = 1'b0;
  logic        vSync = 1'b0;
  logic        dataEn = 1'b0;
  logic [2:0]  laneData;
  logic [2:0]  laneOe;
  logic        fwdClk;

  int total = 0;
  int bad = 0;
  int pixNo = 0;
  logic [26:0] prevWord = '0;
  logic curPol = 1'b0;
  logic collide = 1'b0;

  always #4 clk = ~clk;

  pix_lane_serializer u_pix_lane_serializer (
    .clk(clk), .rstN(rstN), .pixClk(pixClk), .bitEn(bitEn), .clkPol(clkPol),
    .busSwap(busSwap), .linkSel(linkSel), .pixData(pixData), .hSync(hSync),
    .vSync(vSync), .dataEn(dataEn), .laneData(laneData), .laneOe(laneOe),
    .fwdClk(fwdClk)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (pixel %0d)", req, got, exp, pixNo);
    end
  endtask

  function automatic int lanesOf(input logic [1:0] ls);
    if (ls == 2'b01) return 2;
    if (ls == 2'b10) return 3;
    return 1;
  endfunction

  function automatic logic [23:0] rev24(input logic [23:0] v);
    logic [23:0] r;
    for (int b = 0; b < 24; b++) r[b] = v[23-b];
    return r;
  endfunction

  // word layout {de, vs, hs, R7..R0, G7..G0, B7..B0}
  function automatic logic [29:0] expFrame(input logic [26:0] w);
    logic [29:0] f;
    int ones;
    f = '0;
    ones = 0;
    for (int b = 0; b < 27; b++) ones += w[b];
    f[0] = (ones % 2 == 0);
    for (int b = 0; b < 24; b++) f[1+b] = w[23-b];
    f[25] = w[24];
    f[26] = w[25];
    f[27] = w[26];
    return f;
  endfunction

  task automatic setPol(input logic p);
    if (p != curPol) begin
      @(negedge clk);
      clkPol = p;
      pixClk = p;   // opposite of the new capture level: no capture here
      bitEn  = 1'b0;
      curPol = p;
    end
  endtask

  task automatic sendPixel(input logic [23:0] bus, input logic [2:0] ctl,
                           input logic swap, input logic [1:0] ls);
    logic [29:0] f;
    logic [2:0]  expLanes;
    logic [2:0]  expOe;
    logic        capLvl;
    int n;
    int steps;
    n = lanesOf(ls);
    steps = 30 / n;
    f = expFrame(prevWord);
    capLvl = ~curPol;
    expOe = 3'((1 << n) - 1);
    @(negedge clk);
    pixClk = capLvl;
    pixData = bus;
    {dataEn, vSync, hSync} = ctl;
    busSwap = swap;
    linkSel = ls;
    bitEn = collide;
    for (int j = 0; j < steps; j++) begin
      @(negedge clk);
      bitEn = 1'b0;
      for (int i = 0; i < 3; i++) expLanes[i] = (i < n) ? f[j*n+i] : 1'b0;
      check(collide ? "R4 R9 lane bits (R1 R2 R6 R7 R8)" : "R4 lane bits (R1 R2 R6 R7 R8)",
            32'(laneData), 32'(expLanes));
      check("R3 R5 lane enables", 32'(laneOe), 32'(expOe));
      if (j == 0) check("R10 forwarded clock", 32'(fwdClk), 32'(capLvl));
      if (j == steps / 2) begin
        pixClk = ~capLvl;           // non-capture edge with junk inputs (R6)
        pixData = ~bus;
        {dataEn, vSync, hSync} = ~ctl;
        busSwap = ~swap;
        linkSel = ~ls;
      end
      bitEn = 1'b1;
      @(negedge clk);
      bitEn = 1'b0;
    end
    prevWord = {ctl, swap ? rev24(bus) : bus};
    pixNo++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [23:0] bus;
    repeat (3) @(negedge clk);
    check("R11 reset laneData", 32'(laneData), 32'd0);
    check("R11 reset laneOe", 32'(laneOe), 32'd0);
    check("R11 reset fwdClk", 32'(fwdClk), 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R5 no enable before capture", 32'(laneOe), 32'd0);
    for (int p = 0; p < 2; p++) begin
      setPol(p[0]);
      for (int ls = 0; ls < 4; ls++) begin
        for (int sw = 0; sw < 2; sw++) begin
          for (int col = 0; col < 2; col++) begin
            collide = col[0];
            for (int k = 0; k < 3; k++) begin
              bus = 24'(pixNo * 32'h009E3779 + 32'h135);
              if (pixNo % 7 == 3) bus = 24'hFFFFFF;
              if (pixNo % 11 == 5) bus = 24'h000000;
              sendPixel(bus, 3'(pixNo), sw[0], 2'(ls));
            end
          end
        end
      end
    end
    collide = 1'b0;
    sendPixel(24'h5A5A5A, 3'b101, 1'b0, 2'b10);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule